// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write side of a byte-wide nonvolatile memory with a page buffer. Write strobes arrive already sampled into single-cycle load events, each carrying an address and a data byte. The first load of an operation fixes the page (the upper address bits). Later loads to that page fill a page buffer and set a per-byte flag; they may come in any order, and a byte may be loaded more than once.

When no accepted load has arrived for a full byte-load window, the block stops taking data and enters a timed programming period with busy asserted. At the end of that period it writes only the flagged bytes into the storage row of the latched page, clears all flags and drops busy. A registered read port returns stored bytes. The byte-load window and the programming time are counted in clock cycles and set by parameters.

The low `$clog2(PAGE_BYTES)` address bits (six for a 64-byte page) select the byte within the page. The upper `ROW_W` bits (seven by default, giving 8192 bytes) select the page.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, busy_o is low and every stored byte reads as 0x00.
- R2: A load while idle latches the page bits of its address and begins a load period. busy_o stays low for the whole load period.
- R3: During a load period, loads to the latched page are buffered in any order. A later load to the same byte replaces the earlier value, and the last value loaded is the one stored.
- R4: A load whose page bits differ from the latched page is ignored. It writes nothing and does not restart the byte-load window.
- R5: Let the last accepted load be sampled at edge t. A load at any edge up to t+LOAD_WIN is still accepted. If no load is accepted by then, busy_o rises after edge t+LOAD_WIN.
- R6: busy_o stays high for exactly WRITE_CYC cycles. Loads presented while busy are ignored.
- R7: At the end of programming, only the bytes flagged in this operation are written. Every other byte of the page, and every other page, keeps its value.
- R8: All byte flags are cleared when programming ends. A later operation writes only the bytes that it loaded itself.
- R9: rd_data_o gives the byte stored at rd_addr_i as sampled at the previous clock edge. A commit becomes visible from the read that is sampled after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Single-cycle byte load event |
| load_addr_i | input | ROW_W+log2(PAGE_BYTES) | Load address: page in the upper bits, byte in the lower bits |
| load_data_i | input | 8 | Load data byte |
| rd_addr_i | input | ROW_W+log2(PAGE_BYTES) | Read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | High during the programming period |

## Verification
The hardest cases to reach from the ports sit at the edges of the byte-load window. One is a load that arrives on the very last accepted edge. Another is a load to a foreign page that lands inside the window without resetting it. The stimulus counts idle cycles exactly from the last accepted load: it places a foreign-page load in the gap, then an overwrite on edge LOAD_WIN, and then samples busy one cycle before the expected rise and again at the rise. The stale-flag case works as follows. The bench first commits a byte at one offset. It then starts a second operation that loads a different offset only. It then reads back the first offset in the new page, which must still be zero.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_timer.sv
module plc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || hit_o)   cnt_q <= '0;
    else if (run_i)            cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_i)); // R5
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
  parameter int COL_W = 6,
  localparam int BYTES = 1 << COL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [COL_W-1:0]      idx_i,
  input  logic [7:0]            data_i,
  input  logic                  clr_i,
  output logic [BYTES-1:0][7:0] buf_o,
  output logic [BYTES-1:0]      mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o  <= '0;
      mask_o <= '0;
    end else begin
      if (clr_i) mask_o <= '0;
      if (wr_i) begin
        buf_o[idx_i]  <= data_i;
        mask_o[idx_i] <= 1'b1;
      end
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mask_o[$past(idx_i)]); // R3
  AST_LAST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (buf_o[$past(idx_i)] == $past(data_i))); // R3
endmodule

// File: rtl/plc_array.sv
module plc_array #(
  parameter int ROW_W = 7,
  parameter int COL_W = 6,
  localparam int ROWS   = 1 << ROW_W,
  localparam int BYTES  = 1 << COL_W,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [BYTES-1:0][7:0] buf_i,
  input  logic [BYTES-1:0]      mask_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o
);
  logic [BYTES-1:0][7:0] mem_q [ROWS];
  logic [BYTES-1:0][7:0] merged;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[b] = mask_i[b] ? buf_i[b] : mem_q[row_i][b];

    AST_UNFLAGGED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && !mask_i[b]) |=>
        (mem_q[$past(row_i)][b] == $past(mem_q[row_i][b]))); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
      rd_data_o <= '0;
    end else begin
      rd_data_o <= mem_q[rd_addr_i[ADDR_W-1:COL_W]][rd_addr_i[COL_W-1:0]];
      if (commit_i) mem_q[row_i] <= merged;
    end
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int ROW_W      = 7,
  parameter int LOAD_WIN   = 7500,
  parameter int WRITE_CYC  = 500000,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [7:0]        load_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int MAX_LIM = (LOAD_WIN > WRITE_CYC) ? LOAD_WIN : WRITE_CYC;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] LW_C = CNT_W'(LOAD_WIN);
  localparam logic [CNT_W-1:0] WC_C = CNT_W'(WRITE_CYC);

  plc_state_e st_q;
  logic [ROW_W-1:0] page_q;
  logic [ROW_W-1:0] ld_row;
  logic [COL_W-1:0] ld_col;
  logic accept, hit, commit, same_page;
  logic [PAGE_BYTES-1:0][7:0] buf_w;
  logic [PAGE_BYTES-1:0]      mask_w;

  assign ld_row    = load_addr_i[ADDR_W-1:COL_W];
  assign ld_col    = load_addr_i[COL_W-1:0];
  assign same_page = (ld_row == page_q);
  assign accept    = load_i && ((st_q == ST_IDLE) || ((st_q == ST_LOAD) && same_page));
  assign commit    = (st_q == ST_PROG) && hit;
  assign busy_o    = (st_q == ST_PROG);

  plc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .run_i (st_q != ST_IDLE),
    .lim_i ((st_q == ST_PROG) ? WC_C : LW_C),
    .hit_o (hit)
  );

  plc_page_buf #(.COL_W(COL_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (accept),
    .idx_i (ld_col),
    .data_i(load_data_i),
    .clr_i (commit),
    .buf_o (buf_w),
    .mask_o(mask_w)
  );

  plc_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .row_i    (page_q),
    .buf_i    (buf_w),
    .mask_i   (mask_w),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_LOAD;
          page_q <= ld_row;
        end
        ST_LOAD: if (!accept && hit) st_q <= ST_PROG;
        ST_PROG: if (hit) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // checker-only count of busy cycles
  logic [CNT_W-1:0] busy_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_len_q <= '0;
    else if (!busy_o) busy_len_q <= '0;
    else              busy_len_q <= busy_len_q + 1'b1;
  end

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == WC_C)); // R6
  AST_BUSY_HOLDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit) |=> $stable(mask_w)); // R6
  AST_MASK_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (mask_w == '0)); // R8
  AST_NO_LOAD_AT_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(load_i && same_page)); // R5
  AST_FOREIGN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_LOAD) && load_i && !same_page) |=> $stable(mask_w)); // R4
  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD) |=> $stable(page_q)); // R2
endmodule

// File: tb/page_load_ctrl_test.sv
`timescale 1ns/1ps
module page_load_ctrl_test;
  localparam int LW = 8;
  localparam int WC = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [12:0] load_addr_i = '0;
  logic [7:0]  load_data_i = '0;
  logic [12:0] rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        busy_o;

  always #2 clk_i = ~clk_i;

  page_load_ctrl #(.PAGE_BYTES(64), .ROW_W(7), .LOAD_WIN(LW), .WRITE_CYC(WC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_addr_i(load_addr_i),
    .load_data_i(load_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] ref_mem [8192];
  int  pend [int];
  int  ph, pg, quiet, left;
  logic [7:0] m_rd;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (ref_mem[i]) ref_mem[i] = 8'h00;
      pend.delete();
      ph = 0; pg = 0; quiet = 0; left = 0; m_rd = 8'h00;
    end else begin
      m_rd = ref_mem[rd_addr_i];
      if (ph == 2) begin
        left--;
        if (left == 0) begin
          foreach (pend[k]) ref_mem[pg*64 + k] = 8'(pend[k]);
          pend.delete();
          ph = 0;
        end
      end else if (load_i && (ph == 0 || int'(load_addr_i[12:6]) == pg)) begin
        if (ph == 0) pg = int'(load_addr_i[12:6]);
        pend[int'(load_addr_i[5:0])] = int'(load_data_i);
        quiet = 0;
        ph = 1;
      end else if (ph == 1) begin
        quiet++;
        if (quiet == LW) begin ph = 2; left = WC; end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && cmp_en) begin
      check("R5/R6 busy vs model", int'(busy_o), int'(ph == 2));
      check("R9 rd_data vs model", int'(rd_data_o), int'(m_rd));
    end
  end

  // tasks enter and leave at a falling edge
  task automatic ld(input int row, input int col, input int data);
    load_i = 1'b1;
    load_addr_i = 13'((row << 6) | col);
    load_data_i = 8'(data);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(input int row, input int col, output int data);
    rd_addr_i = 13'((row << 6) | col);
    @(negedge clk_i);
    data = int'(rd_data_o);
  endtask

  task automatic wait_done();
    while (!busy_o) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog: got running expected finished");
    summary();
    $finish;
  end

  initial begin
    int v;
    int bcnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cmp_en = 1'b1;

    check("R1 busy after reset", int'(busy_o), 0);
    rd(0, 0, v);    check("R1 byte 0 after reset", v, 0);
    rd(127, 63, v); check("R1 last byte after reset", v, 0);

    ld(3, 10, 8'hA1);
    check("R2 busy low while loading", int'(busy_o), 0);
    ld(3, 2, 8'hB2);
    ld(5, 0, 8'hEE);            // foreign page, inside the window
    idle(LW - 2);
    check("R5 busy before window end", int'(busy_o), 0);
    ld(3, 10, 8'hC3);           // last accepted edge of the window
    idle(LW - 1);
    check("R5 busy one cycle before expiry", int'(busy_o), 0);
    idle(1);
    check("R5 busy at expiry", int'(busy_o), 1);
    bcnt = 1;
    ld(3, 11, 8'h99);           // ignored while busy
    while (busy_o) begin bcnt++; @(negedge clk_i); end
    check("R6 busy length", bcnt, WC);

    rd(3, 10, v); check("R3 overwritten byte", v, 8'hC3);
    rd(3, 2, v);  check("R3 second byte", v, 8'hB2);
    rd(3, 11, v); check("R6 load during busy ignored", v, 0);
    rd(5, 0, v);  check("R4 foreign page ignored", v, 0);
    rd(3, 0, v);  check("R7 unloaded byte untouched", v, 0);

    ld(7, 2, 8'h5A);
    wait_done();
    rd(7, 2, v);  check("R8 new byte stored", v, 8'h5A);
    rd(7, 10, v); check("R8 stale flag not reused", v, 0);

    ld(3, 11, 8'h77);
    wait_done();
    rd(3, 11, v); check("R7 loaded byte stored", v, 8'h77);
    rd(3, 10, v); check("R7 earlier byte kept", v, 8'hC3);
    rd(3, 2, v);  check("R7 earlier byte kept", v, 8'hB2);

    for (int i = 63; i >= 0; i--) ld(127, i, i ^ 8'h5A);
    wait_done();
    rd(127, 0, v);  check("R3 full page byte 0", v, 8'h5A);
    rd(127, 63, v); check("R3 full page byte 63", v, 63 ^ 8'h5A);
    rd(127, 31, v); check("R3 full page byte 31", v, 31 ^ 8'h5A);
    rd(126, 63, v); check("R7 neighbour page untouched", v, 0);

    idle(2);
    summary();
    $finish;
  end
endmodule